// File: doc/BRIEF.md
# Half-Bridge Gate Interlock and Overcurrent Guard

This block sits between a motor controller's active-low gate commands and the gate-drive enables of a three-phase inverter that also has a brake switch. It has two jobs. First, it refuses to turn on both switches of one half-bridge together. When the upper and lower commands of a phase conflict, it turns off both switches of that phase and holds them off. Second, it turns off any single phase switch whose overcurrent sense bit is raised. The two cases have different release rules. An interlock is released by a new, clean turn-on command on that phase. An overcurrent shutdown is released at the next turn-on command of the switch concerned.

All inputs are asynchronous to the clock. They pass through a two-flop synchronizer, and a third register keeps the previous synchronized command for edge detection. Every output is registered, so a clean input change shows up at the outputs on the third rising clock edge after it. One active-low fault flag reports every active protection state. The brake switch follows its own command and has no protection.

Top module: `hb_guard`

## Requirements
- R1: While `rst` is high at a clock edge, all gate enables go to 0 and `fault_n` goes to 1.
- R2: With no protection active, bit i of `up_cmd_n` or `lo_cmd_n` held at 0 sets bit i of `up_gate` or `lo_gate` to 1, on the third rising edge after the input change. Holding the bit at 1 sets the enable to 0.
- R3: If `up_cmd_n[i]` and `lo_cmd_n[i]` are both 0, then `up_gate[i]` and `lo_gate[i]` are both 0 and `fault_n` is 0. The two enables of a phase are never 1 together.
- R4: Once phase i has seen a conflict, both of its enables stay 0 and `fault_n` stays 0 after the conflict ends, including while one command alone stays low or both stay high.
- R5: A latched phase is released by the first high-to-low change on one of its two commands that occurs while the other command is high. The switch commanded by that edge turns on in the same cycle the release takes effect. A command that falls again while its partner is still low creates a new conflict and keeps the phase latched.
- R6: An interlock on one phase has no effect on the enables of the other phases.
- R7: `up_oc[i]` (or `lo_oc[i]`) at 1 turns off only `up_gate[i]` (or `lo_gate[i]`) and sets `fault_n` to 0. The partner switch and the other phases keep following their commands.
- R8: An overcurrent shutdown stays in place after the sense bit returns to 0. It clears at the next high-to-low change of that switch's command, provided the sense bit is 0 at that point; the switch then turns on.
- R9: `brk_gate` is the inverse of `brk_cmd_n` with the same three-edge latency. It is unaffected by any interlock or overcurrent state and never causes `fault_n` to go to 0.
- R10: `fault_n` is 0 exactly while at least one interlock latch or overcurrent shutdown is active, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up_cmd_n | input | NPH | Upper switch commands, one bit per phase, 0 = on |
| lo_cmd_n | input | NPH | Lower switch commands, one bit per phase, 0 = on |
| brk_cmd_n | input | 1 | Brake switch command, 0 = on |
| up_oc | input | NPH | Upper switch overcurrent sense, 1 = overcurrent |
| lo_oc | input | NPH | Lower switch overcurrent sense, 1 = overcurrent |
| up_gate | output | NPH | Upper gate enables, 1 = on |
| lo_gate | output | NPH | Lower gate enables, 1 = on |
| brk_gate | output | 1 | Brake gate enable, 1 = on |
| fault_n | output | 1 | Shared fault flag, 0 = fault |

## Verification
The bench builds the block with the default NPH = 3. This gives three independent phases, so it can check that an interlock or overcurrent shutdown on phase 0 leaves phases 1 and 2 switching, and that two phases can be in fault together. With three bits per command vector, the stimulus table can mix conflicting and clean phases in a single vector. The directed tests then follow the latch through its whole sequence: conflict, partial removal, re-conflict while one command is stuck low, and release.

// File: rtl/hb_guard.sv
module hb_guard #(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NPH-1:0] up_cmd_n,
  input  logic [NPH-1:0] lo_cmd_n,
  input  logic           brk_cmd_n,
  input  logic [NPH-1:0] up_oc,
  input  logic [NPH-1:0] lo_oc,
  output logic [NPH-1:0] up_gate,
  output logic [NPH-1:0] lo_gate,
  output logic           brk_gate,
  output logic           fault_n
);
  localparam int W = 4*NPH + 1;
  localparam logic [W-1:0] IDLE = {1'b1, {2*NPH{1'b0}}, {2*NPH{1'b1}}};

  logic [W-1:0]     s1, s2;
  logic [2*NPH-1:0] prev;
  logic [NPH-1:0]   ilk_q, ocu_q, ocl_q;

  logic [NPH-1:0] u, l, su, sl, fall_u, fall_l, conflict;
  logic [NPH-1:0] ilk_d, ocu_d, ocl_d;
  logic           brk;

  assign u   = s2[NPH-1:0];
  assign l   = s2[2*NPH-1:NPH];
  assign su  = s2[3*NPH-1:2*NPH];
  assign sl  = s2[4*NPH-1:3*NPH];
  assign brk = s2[W-1];

  assign fall_u   = prev[NPH-1:0] & ~u;
  assign fall_l   = prev[2*NPH-1:NPH] & ~l;
  assign conflict = ~u & ~l;

  assign ilk_d = conflict | (ilk_q & ~(fall_u | fall_l));
  assign ocu_d = su | (ocu_q & ~fall_u);
  assign ocl_d = sl | (ocl_q & ~fall_l);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1       <= IDLE;
      s2       <= IDLE;
      prev     <= {2*NPH{1'b1}};
      ilk_q    <= '0;
      ocu_q    <= '0;
      ocl_q    <= '0;
      up_gate  <= '0;
      lo_gate  <= '0;
      brk_gate <= 1'b0;
      fault_n  <= 1'b1;
    end else begin
      s1       <= {brk_cmd_n, lo_oc, up_oc, lo_cmd_n, up_cmd_n};
      s2       <= s1;
      prev     <= s2[2*NPH-1:0];
      ilk_q    <= ilk_d;
      ocu_q    <= ocu_d;
      ocl_q    <= ocl_d;
      up_gate  <= ~u & ~ilk_d & ~ocu_d;
      lo_gate  <= ~l & ~ilk_d & ~ocl_d;
      brk_gate <= ~brk;
      fault_n  <= ~(|{ilk_d, ocu_d, ocl_d});
    end
  end

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
    (up_gate & lo_gate) == '0);  // R3
  AST_FAULT_SET: assert property (@(posedge clk) disable iff (rst)
    (|{ilk_q, ocu_q, ocl_q}) |-> !fault_n);  // R10
  AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !(|{ilk_q, ocu_q, ocl_q}) |-> fault_n);  // R10
  AST_BRAKE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    brk_gate == !$past(brk));  // R9

  for (genvar i = 0; i < NPH; i++) begin : g_chk
    AST_CONFLICT_OFF: assert property (@(posedge clk) disable iff (rst)
      conflict[i] |=> !up_gate[i] && !lo_gate[i] && !fault_n);  // R3
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
      ilk_q[i] && !fall_u[i] && !fall_l[i] |=> !up_gate[i] && !lo_gate[i]);  // R4
    AST_LATCH_RELEASE: assert property (@(posedge clk) disable iff (rst)
      ilk_q[i] && fall_u[i] && l[i] && !su[i] |=> up_gate[i]);  // R5
    AST_OC_UP_OFF: assert property (@(posedge clk) disable iff (rst)
      su[i] |=> !up_gate[i] && !fault_n);  // R7
    AST_OC_LO_OFF: assert property (@(posedge clk) disable iff (rst)
      sl[i] |=> !lo_gate[i] && !fault_n);  // R7
    AST_OC_HOLD: assert property (@(posedge clk) disable iff (rst)
      ocu_q[i] && !fall_u[i] |=> !up_gate[i]);  // R8
  end
endmodule

// File: tb/sim_hb_guard.sv
module sim_hb_guard;
  localparam int NPH = 3;
  logic clk = 1'b0, rst = 1'b1;
  logic [NPH-1:0] up_cmd_n = '1, lo_cmd_n = '1, up_oc = '0, lo_oc = '0;
  logic brk_cmd_n = 1'b1;
  logic [NPH-1:0] up_gate, lo_gate;
  logic brk_gate, fault_n;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hb_guard #(.NPH(NPH)) u0 (.clk, .rst, .up_cmd_n, .lo_cmd_n, .brk_cmd_n,
    .up_oc, .lo_oc, .up_gate, .lo_gate, .brk_gate, .fault_n);

  // {up_cmd_n, lo_cmd_n, brk_cmd_n, up_oc, lo_oc, exp_up, exp_lo, exp_brk, exp_fault_n}
  localparam logic [20:0] TBL [8] = '{
    {3'b111, 3'b111, 1'b1, 3'b000, 3'b000, 3'b000, 3'b000, 1'b0, 1'b1},  // R2 idle
    {3'b110, 3'b111, 1'b1, 3'b000, 3'b000, 3'b001, 3'b000, 1'b0, 1'b1},  // R2
    {3'b111, 3'b101, 1'b0, 3'b000, 3'b000, 3'b000, 3'b010, 1'b1, 1'b1},  // R2 R9
    {3'b010, 3'b101, 1'b1, 3'b000, 3'b000, 3'b101, 3'b010, 1'b0, 1'b1},  // R2
    {3'b110, 3'b110, 1'b1, 3'b000, 3'b000, 3'b000, 3'b000, 1'b0, 1'b0},  // R3
    {3'b101, 3'b110, 1'b0, 3'b000, 3'b000, 3'b010, 3'b001, 1'b1, 1'b1},  // R2 R9
    {3'b011, 3'b111, 1'b1, 3'b100, 3'b000, 3'b000, 3'b000, 1'b0, 1'b0},  // R7
    {3'b110, 3'b011, 1'b1, 3'b000, 3'b100, 3'b001, 3'b000, 1'b0, 1'b0}   // R7
  };

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; up_cmd_n = '1; lo_cmd_n = '1; brk_cmd_n = 1'b1; up_oc = '0; lo_oc = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic chk(string tag, logic [NPH-1:0] eu, logic [NPH-1:0] el, logic eb, logic ef);
    n_chk++;
    if (up_gate !== eu || lo_gate !== el || brk_gate !== eb || fault_n !== ef) begin
      n_bad++;
      $display("FAIL %s: up=%b lo=%b brk=%b flt_n=%b expected up=%b lo=%b brk=%b flt_n=%b",
               tag, up_gate, lo_gate, brk_gate, fault_n, eu, el, eb, ef);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 in reset", 3'b000, 3'b000, 1'b0, 1'b1);

    for (int k = 0; k < 8; k++) begin
      do_reset();
      {up_cmd_n, lo_cmd_n, brk_cmd_n, up_oc, lo_oc} = TBL[k][20:8];
      settle();
      chk($sformatf("R2/R3/R7/R9 vector %0d", k), TBL[k][7:5], TBL[k][4:2], TBL[k][1], TBL[k][0]);
    end

    // R1: reset after a fault
    @(negedge clk); rst = 1'b1; up_cmd_n = 3'b110; lo_cmd_n = 3'b110;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R1 reset clears", 3'b000, 3'b000, 1'b0, 1'b1);

    // Interlock latch sequence on phase 0
    do_reset();
    up_cmd_n = 3'b110; settle();
    chk("R2 phase0 upper on", 3'b001, 3'b000, 1'b0, 1'b1);
    lo_cmd_n = 3'b110; settle();
    chk("R3 conflict", 3'b000, 3'b000, 1'b0, 1'b0);
    up_cmd_n = 3'b111; settle();
    chk("R4 held with lower alone low", 3'b000, 3'b000, 1'b0, 1'b0);
    up_cmd_n = 3'b101; brk_cmd_n = 1'b0; settle();
    chk("R6 R9 phase1 and brake run during latch", 3'b010, 3'b000, 1'b1, 1'b0);
    up_cmd_n = 3'b110; settle();
    chk("R5 re-conflict while lower stuck", 3'b000, 3'b000, 1'b1, 1'b0);
    up_cmd_n = 3'b111; lo_cmd_n = 3'b111; settle();
    chk("R4 held with both high", 3'b000, 3'b000, 1'b1, 1'b0);
    lo_cmd_n = 3'b110; settle();
    chk("R5 release by lower edge", 3'b000, 3'b001, 1'b1, 1'b1);

    // Release timing: third rising edge after the releasing edge
    do_reset();
    up_cmd_n = 3'b110; lo_cmd_n = 3'b110; settle();
    up_cmd_n = 3'b111; lo_cmd_n = 3'b111; settle();
    up_cmd_n = 3'b110;
    repeat (2) @(posedge clk); @(negedge clk);
    chk("R5 not yet released after 2 edges", 3'b000, 3'b000, 1'b0, 1'b0);
    @(posedge clk); @(negedge clk);
    chk("R5 released on 3rd edge", 3'b001, 3'b000, 1'b0, 1'b1);

    // Overcurrent pulse-by-pulse on phase 0 upper, phase 1 lower active
    do_reset();
    up_cmd_n = 3'b110; lo_cmd_n = 3'b101; settle();
    up_oc = 3'b001; settle();
    chk("R7 only offending switch off", 3'b000, 3'b010, 1'b0, 1'b0);
    up_oc = 3'b000; settle();
    chk("R8 held after sense drops", 3'b000, 3'b010, 1'b0, 1'b0);
    up_cmd_n = 3'b111; settle();
    up_oc = 3'b001; up_cmd_n = 3'b110; settle();
    chk("R8 not cleared while sense high", 3'b000, 3'b010, 1'b0, 1'b0);
    up_oc = 3'b000; up_cmd_n = 3'b111; settle();
    chk("R10 flag stays until clear", 3'b000, 3'b010, 1'b0, 1'b0);
    up_cmd_n = 3'b110; settle();
    chk("R8 cleared on next on-command", 3'b001, 3'b010, 1'b0, 1'b1);

    // Two faults at once: flag remains while either remains
    do_reset();
    up_cmd_n = 3'b110; lo_cmd_n = 3'b010; lo_oc = 3'b100; settle();
    chk("R10 two faults", 3'b000, 3'b000, 1'b0, 1'b0);
    lo_oc = 3'b000; lo_cmd_n = 3'b111; settle();
    lo_cmd_n = 3'b011; settle();
    chk("R10 interlock still flags", 3'b000, 3'b100, 1'b0, 1'b0);
    up_cmd_n = 3'b111; settle();
    up_cmd_n = 3'b110; settle();
    chk("R10 all clear", 3'b001, 3'b100, 1'b0, 1'b1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule